// File: doc/BRIEF.md
# Slice-Locked Event Word Serializer

This block carries event words from upstream processing logic onto a 16-line output bus that is cut into fixed time slices. The bus is split into four lane groups of four lines each. Each group sends at most one word per slice, so the bus moves at most four words per slice. A slice lasts 8 clocks with 32-bit words or 16 clocks with 64-bit words. Every line carries one bit per clock. Within a group the word goes out four bits per clock, most significant nibble first.

Words arrive on a valid/ready interface. An accepted word goes round-robin to one of four per-group FIFOs, each four words deep. At every slice boundary each group pops its FIFO head into a shift register. A group with nothing pending sends an all-zero word, and receivers read that value as "no event". The block also outputs the clock, a slice strobe that is high on the first clock of each slice, and a flag giving the word length of the current slice. All three are aligned to the data.

A slice-timing state machine has three states. SL_IDLE lasts one cycle after reset. SL_BOUNDARY is the first slot of a slice and carries the strobe. SL_SHIFT covers the remaining slots. There are three transitions: SL_IDLE to SL_BOUNDARY on the first clock after reset, SL_BOUNDARY to SL_SHIFT on the next clock, and SL_SHIFT to SL_BOUNDARY after the last slot of a slice. Otherwise SL_SHIFT stays in SL_SHIFT. Every entry into SL_BOUNDARY is a load edge. On a load edge the groups pop their FIFOs and the mode input is sampled.

Top module: `slice_event_serializer`

## Requirements
- R1: While reset is held, and during the single SL_IDLE cycle after it, `slice_strobe` is low and all of `lanes_out` are zero. The first slice begins on the next clock.
- R2: A slice lasts 8 clocks when the sampled mode is 0 and 16 clocks when it is 1. `slice_strobe` is high on exactly the first clock of each slice.
- R3: `mode_long` is sampled only on a load edge. `slice_long` gives the mode of the slice in progress and changes only on a load edge.
- R4: In a slice of word width W (32 or 64), during slot s (counted from 0 at the strobe), line k of group g (`lanes_out[4g+k]`) carries word bit W-4-4s+k. A 32-bit slice sends bits 31:0 of the stored word.
- R5: On each load edge every group with a pending word pops exactly one word from its FIFO head. Each group delivers its words in the order they were accepted.
- R6: A group whose FIFO is empty on a load edge sends all zeros for the whole slice.
- R7: An accepted non-zero word goes to the first non-full group at or after a rotating pointer. The pointer then moves to the group after the one chosen. The full test uses FIFO occupancy before any pop in the same cycle.
- R8: `in_ready` is low exactly when all four FIFOs each hold four words. No word is taken while it is low.
- R9: An all-zero input word offered while `in_ready` is high is consumed and dropped. It takes no FIFO slot and does not move the pointer. In 32-bit mode the sender drives bits 63:32 to zero.
- R10: `slice_clk_out` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_long | input | 1 | 1 selects 16-clock slices with 64-bit words, 0 selects 8-clock slices with 32-bit words |
| in_valid | input | 1 | Upstream word valid |
| in_word | input | 64 | Upstream event word (low 32 bits used in short mode) |
| in_ready | output | 1 | Space available in at least one group FIFO |
| slice_clk_out | output | 1 | Forwarded clock for the receiver |
| slice_strobe | output | 1 | High on the first clock of each slice |
| slice_long | output | 1 | Word length of the current slice |
| lanes_out | output | 16 | Serial data, four lines per lane group |

## Verification
The hardest states to reach from the ports are the FIFO-full backpressure edge and a mode change that lands between two load edges while words queued under the old mode are still pending. The stimulus reaches backpressure with a long unbroken burst. Four groups drain only four words per slice while a new word can arrive every clock, so all sixteen slots fill and `in_ready` drops. Mode is flipped mid-slice with words queued, so the remaining slots of that slice must keep the old length and the next slice takes the new one. A behavioural model with per-group queues predicts every lane bit, the strobe, ready and the mode flag on every clock. A bench-side deserializer rebuilds each delivered word and compares it with the word the model popped.

// File: rtl/sev_pkg.sv
package sev_pkg;
    typedef enum logic [1:0] {
        SL_IDLE,
        SL_BOUNDARY,
        SL_SHIFT
    } slice_state_t;
endpackage

// File: rtl/sev_slice_timer.sv
module sev_slice_timer #(
    parameter int SHORT_SLOTS = 8,
    parameter int LONG_SLOTS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_long,
    output logic load_now,
    output logic load_long,
    output logic strobe,
    output logic slice_long
);
    import sev_pkg::*;

    localparam int CW = $clog2(LONG_SLOTS);

    slice_state_t state_q, state_d;
    logic [CW-1:0] slot_q;
    logic          long_q;
    logic          last_slot;

    assign last_slot = long_q ? (slot_q == CW'(LONG_SLOTS - 1))
                              : (slot_q == CW'(SHORT_SLOTS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            slot_q  <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_now) begin
                slot_q <= '0;
                long_q <= mode_long;
            end else if (state_q != SL_IDLE) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE:     state_d = SL_BOUNDARY;
            SL_BOUNDARY: state_d = SL_SHIFT;
            SL_SHIFT:    state_d = last_slot ? SL_BOUNDARY : SL_SHIFT;
            default:     state_d = SL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_now   = (state_d == SL_BOUNDARY);
        load_long  = mode_long;
        strobe     = (state_q == SL_BOUNDARY);
        slice_long = long_q;
    end

    // a slice spans at least two clocks, so strobes never touch
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // mode flag moves only on a load edge
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_now |=> $stable(slice_long));
endmodule

// File: rtl/sev_lane_fifo.sv
module sev_lane_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wp_q] <= din;
                wp_q      <= bump(wp_q);
            end
            if (pop) rp_q <= bump(rp_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem[rp_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sev_lane_shifter.sv
module sev_lane_shifter #(
    parameter int W       = 64,
    parameter int SHORT_W = 32,
    parameter int LINES   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_long,
    input  logic [W-1:0]     word,
    output logic [LINES-1:0] nibble
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_long ? word : {word[SHORT_W-1:0], {(W - SHORT_W){1'b0}}};
        end else begin
            sr_q <= sr_q << LINES;
        end
    end

    assign nibble = sr_q[W-1 -: LINES];
endmodule

// File: rtl/slice_event_serializer.sv
module slice_event_serializer #(
    parameter int GROUPS     = 4,
    parameter int LINES      = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int SHORT_W    = 32,
    parameter int LONG_W     = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_long,
    input  logic                      in_valid,
    input  logic [LONG_W-1:0]         in_word,
    output logic                      in_ready,
    output logic                      slice_clk_out,
    output logic                      slice_strobe,
    output logic                      slice_long,
    output logic [GROUPS*LINES-1:0]   lanes_out
);
    localparam int SHORT_SLOTS = SHORT_W / LINES;
    localparam int LONG_SLOTS  = LONG_W / LINES;
    localparam int GPW         = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic              load_now, load_long;
    logic [GROUPS-1:0] full_vec, empty_vec, push_vec;
    logic [GPW-1:0]    ptr_q, sel;
    logic              found, store;

    assign slice_clk_out = clk;

    sev_slice_timer #(
        .SHORT_SLOTS (SHORT_SLOTS),
        .LONG_SLOTS  (LONG_SLOTS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_long  (mode_long),
        .load_now   (load_now),
        .load_long  (load_long),
        .strobe     (slice_strobe),
        .slice_long (slice_long)
    );

    // round-robin pick among groups with space
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < GROUPS; i++) begin
            if (!found && !full_vec[(int'(ptr_q) + i) % GROUPS]) begin
                found = 1'b1;
                sel   = GPW'((int'(ptr_q) + i) % GROUPS);
            end
        end
    end

    assign in_ready = ~&full_vec;
    assign store    = in_valid && in_ready && (|in_word);

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (store) ptr_q <= GPW'((int'(sel) + 1) % GROUPS);
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        logic [LONG_W-1:0] head;
        logic [LONG_W-1:0] next_word;
        logic [LINES-1:0]  nib;

        assign push_vec[g] = store && (sel == GPW'(g));
        assign next_word   = empty_vec[g] ? '0 : head;

        sev_lane_fifo #(
            .W     (LONG_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_vec[g]),
            .din   (in_word),
            .pop   (load_now && !empty_vec[g]),
            .dout  (head),
            .full  (full_vec[g]),
            .empty (empty_vec[g])
        );

        sev_lane_shifter #(
            .W       (LONG_W),
            .SHORT_W (SHORT_W),
            .LINES   (LINES)
        ) u_shift (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_now),
            .load_long (load_long),
            .word      (next_word),
            .nibble    (nib)
        );

        assign lanes_out[g*LINES +: LINES] = nib;
    end

    assert_single_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_vec));

    assert_zero_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word == '0) |-> (push_vec == '0));
endmodule

// File: tb/slice_event_serializer_test.sv
module slice_event_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_long;
    logic        in_valid;
    logic [63:0] in_word;
    logic        in_ready;
    logic        slice_clk_out;
    logic        slice_strobe;
    logic        slice_long;
    logic [15:0] lanes_out;

    slice_event_serializer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_long     (mode_long),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .in_ready      (in_ready),
        .slice_clk_out (slice_clk_out),
        .slice_strobe  (slice_strobe),
        .slice_long    (slice_long),
        .lanes_out     (lanes_out)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    string phase  = "R1";

    // behavioural model state
    logic [63:0] mq [4][$];
    logic [63:0] exp_word [4];
    logic [63:0] rx_acc [4];
    int          m_ptr;
    int          m_cnt;
    int          m_len;
    bit          m_run;
    bit          m_long;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (phase %s) actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    function automatic logic [15:0] model_lanes();
        logic [15:0] v = '0;
        if (m_run) begin
            for (int g = 0; g < 4; g++) begin
                int sh = m_len * 4 - 4 - 4 * m_cnt;
                v[g*4 +: 4] = 4'((exp_word[g] >> sh) & 64'hF);
            end
        end
        return v;
    endfunction

    function automatic bit model_ready();
        for (int g = 0; g < 4; g++)
            if (mq[g].size() < 4) return 1'b1;
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 4; g++) begin
                mq[g].delete();
                exp_word[g] = '0;
                rx_acc[g]   = '0;
            end
            m_ptr = 0; m_cnt = 0; m_len = 8; m_run = 1'b0; m_long = 1'b0;
            check(slice_strobe == 1'b0, "R1 strobe in reset", 64'(slice_strobe), 64'h0);
            check(lanes_out == '0, "R1 lanes in reset", 64'(lanes_out), 64'h0);
        end else begin
            bit rdy, acc, ld;
            int sel;
            logic [15:0] el;
            el  = model_lanes();
            rdy = model_ready();
            check(lanes_out === el, "R4 lane bits", 64'(lanes_out), 64'(el));
            check(slice_strobe === (m_run && m_cnt == 0), "R2 strobe",
                  64'(slice_strobe), 64'(m_run && m_cnt == 0));
            check(in_ready === rdy, "R8 ready", 64'(in_ready), 64'(rdy));
            check(slice_long === m_long, "R3 slice mode", 64'(slice_long), 64'(m_long));
            // receive side: rebuild each group's word over the slice
            if (m_run) begin
                for (int g = 0; g < 4; g++) begin
                    rx_acc[g] = {rx_acc[g][59:0], lanes_out[g*4 +: 4]};
                    if (m_cnt == m_len - 1) begin
                        logic [63:0] got;
                        got = (m_len == 8) ? {32'h0, rx_acc[g][31:0]} : rx_acc[g];
                        check(got === exp_word[g],
                              (exp_word[g] == 0) ? "R6 empty slot word" : "R5 delivered word",
                              got, exp_word[g]);
                    end
                end
            end
            // model step for the coming edge
            acc = in_valid && rdy;
            sel = 0;
            for (int i = 3; i >= 0; i--)
                if (mq[(m_ptr + i) % 4].size() < 4) sel = (m_ptr + i) % 4;
            ld = !m_run || (m_cnt == m_len - 1);
            if (ld) begin
                for (int g = 0; g < 4; g++) begin
                    if (mq[g].size() > 0) begin
                        logic [63:0] w;
                        w = mq[g].pop_front();
                        exp_word[g] = mode_long ? w : (w & 64'hFFFF_FFFF);
                    end else begin
                        exp_word[g] = '0;
                    end
                end
            end
            if (acc && in_word != 0) begin
                mq[sel].push_back(in_word);
                m_ptr = (sel + 1) % 4;
            end
            if (ld) begin
                m_run = 1'b1; m_cnt = 0; m_len = mode_long ? 16 : 8; m_long = mode_long;
            end else begin
                m_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [63:0] w);
        @(posedge clk);
        #2;
        in_valid = v;
        in_word  = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 64'h0);
    endtask

    initial begin
        rst_n = 1'b0; mode_long = 1'b0; in_valid = 1'b0; in_word = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        phase = "R1";
        idle(3);

        // forwarded clock
        @(negedge clk); #1;
        check(slice_clk_out === 1'b0, "R10 clock low", 64'(slice_clk_out), 64'h0);
        @(posedge clk); #1;
        check(slice_clk_out === 1'b1, "R10 clock high", 64'(slice_clk_out), 64'h1);

        phase = "R7";
        for (int k = 1; k <= 4; k++) drive(1'b1, 64'(32'hA500_0000 | k));
        idle(10);
        for (int k = 5; k <= 10; k++) drive(1'b1, 64'(32'h5A00_0100 | k));
        idle(24);

        phase = "R8";
        for (int k = 0; k < 30; k++) drive(1'b1, 64'(32'h1357_0000 | k));
        idle(64);

        phase = "R9";
        drive(1'b1, 64'h0);
        drive(1'b1, 64'(32'h9ABC_0001));
        drive(1'b1, 64'h0);
        drive(1'b1, 64'h0);
        drive(1'b1, 64'(32'h9ABC_0002));
        idle(20);

        phase = "R6";
        idle(24);

        phase = "R3";
        idle(3);
        mode_long = 1'b1;
        for (int k = 0; k < 9; k++) drive(1'b1, {32'hC0DE_0000 | k, 32'h4321_0000 | k});
        idle(40);
        for (int k = 0; k < 6; k++) drive(1'b1, {32'h0BAD_0000 | k, 32'h7654_0000 | k});
        idle(5);
        mode_long = 1'b0;
        idle(80);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule